// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block takes a wide bus of pad inputs and routes eight of them, one per channel, to a parent interrupt controller. Each channel has its own 8-bit pad selector and its own trigger mode. Every output line is active high. Level-low and falling-edge triggers are handled by inverting the selected pad before the trigger stage. A both-edges mode fires on every transition of the pad. In both-edges mode the channel ignores its polarity and single-edge bits.

A selected pad first passes through a two-flop synchroniser. It then passes through a glitch filter whose hold time is set per channel. Software programs everything through four 32-bit word-addressed registers: one for trigger and polarity, two for the packed pad selectors, and one for the filter fields. Software decides which channel serves which pad.

Top module: `gim_irq_mux`

## Requirements
- R1: Reset (synchronous, active low) clears all four registers to zero and drives every output line low.
- R2: Word 0 holds the per-channel edge-enable bits at [7:0], the both-edges bits at [15:8] and the invert bits at [23:16]. Bits [31:24] of word 0 always read zero. Words 1 and 2 hold the 8-bit selectors of channels 0–3 and 4–7, each at bit (channel mod 4)×8. Word 3 holds the 4-bit filter field of channel c at bit c×4. Every stored bit reads back as written.
- R3: A selector value below the pad count picks that pad. A value at or above the pad count picks a constant zero.
- R4: In level mode (edge, both and invert bits all 0, filter 0), the output equals the selected pad. It follows a pad change three clock edges later.
- R5: In level mode with the invert bit set, the output is the complement of the selected pad.
- R6: With the edge bit set and the invert bit clear, a pad rise gives a single one-cycle pulse, high after the third edge and low after the fourth. A pad fall gives no pulse.
- R7: With both the edge bit and the invert bit set, only a pad fall gives the one-cycle pulse, with the same timing as R6.
- R8: With the both-edges bit set, every pad transition gives a one-cycle pulse, whatever the edge and invert bits hold.
- R9: A filter field N>0 changes the filtered value only after the synchronised input has differed from it for 4×N consecutive cycles. The output then moves 2+4×N edges after the pad changes, and shorter pulses are dropped.
- R10: Channels are independent: each one applies its own selector, mode, polarity and filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PADS | Pad input bus |
| irq_out | output | 8 | Active-high line per channel to the parent controller |

## Verification
The bench sweeps every selector value across the whole 8-bit space on a 12-pad build, so that the pad-count boundary is exercised. A design that indexed past the bus would show pad values or X there instead of zero. It measures the exact edge on which level outputs and edge pulses appear. An extra pipeline stage, or a pulse that lasted two cycles, would therefore miscompare. It checks the priority of both-edges mode with the invert bit set; a design that let the invert bit win would miss the rising pulses. It applies a step and a 3-cycle glitch to channels with filter lengths 0 through 7, which catches off-by-one hold counts and filters that pass short glitches.

// File: rtl/gim_pkg.sv
// Shared constants and types for the GPIO interrupt channel mux.
// Assumes a fixed 8-channel register layout on a 32-bit word bus.
package gim_pkg;
    localparam int CH_NUM      = 8;
    localparam int SEL_W       = 8;
    localparam int FLT_W       = 4;
    localparam int FLT_SHIFT   = 2;               // hold time = field << 2
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 2;
    localparam int SEL_PER_REG = DATA_W / SEL_W;

    // Bit positions inside the trigger/polarity word
    localparam int EDGE_LSB = 0;
    localparam int BOTH_LSB = 8;
    localparam int INV_LSB  = 16;
    localparam logic [DATA_W-1:0] TRIG_MASK = 32'h00FF_FFFF;

    // Word addresses
    localparam logic [ADDR_W-1:0] A_TRIG = 2'd0;
    localparam logic [ADDR_W-1:0] A_SELA = 2'd1;
    localparam logic [ADDR_W-1:0] A_SELB = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLT  = 2'd3;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_EDGE  = 2'd1,
        TRIG_BOTH  = 2'd2
    } trig_e;
endpackage

// File: rtl/gim_regs.sv
// Register file: four 32-bit words, word addressed, combinational read.
// Assumes a single-cycle write strobe; unused trigger bits are never stored.
module gim_regs
    import gim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] trig_q,
    output logic [DATA_W-1:0] sela_q,
    output logic [DATA_W-1:0] selb_q,
    output logic [DATA_W-1:0] flt_q
);
    // Store written words; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            sela_q <= '0;
            selb_q <= '0;
            flt_q  <= '0;
        end else if (we) begin
            case (addr)
                A_TRIG:  trig_q <= wdata & TRIG_MASK;
                A_SELA:  sela_q <= wdata;
                A_SELB:  selb_q <= wdata;
                default: flt_q  <= wdata;
            endcase
        end
    end

    // Return the addressed word.
    always_comb begin
        case (addr)
            A_TRIG:  rdata = trig_q;
            A_SELA:  rdata = sela_q;
            A_SELB:  rdata = selb_q;
            default: rdata = flt_q;
        endcase
    end
endmodule

// File: rtl/gim_pad_sel.sv
// Pad selector: picks one pad by index and returns zero for any index at or
// beyond NUM_PADS. Assumes NUM_PADS <= 2**SEL_W.
module gim_pad_sel
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic [NUM_PADS-1:0] pads,
    input  logic [SEL_W-1:0]    sel,
    output logic                picked
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] padded;

    // Extend the pad bus with constant zeros up to the selector range.
    generate
        if (NUM_PADS < SPAN) begin : g_pad_ext
            assign padded = {{(SPAN - NUM_PADS){1'b0}}, pads};
        end else begin : g_pad_full
            assign padded = pads[SPAN-1:0];
        end
    endgenerate

    // Index into the extended bus.
    always_comb picked = padded[sel];
endmodule

// File: rtl/gim_filter.sv
// Synchroniser plus glitch filter. Two flops bring the pad into the clock
// domain. A field of 0 lets the synchronised value through after one register.
// A field N>0 needs 4*N consecutive differing cycles before the output moves.
module gim_filter
    import gim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] flt,
    output logic             dout
);
    localparam int CNT_W = FLT_W + FLT_SHIFT;

    logic             s1_q, s2_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Hold limit in cycles.
    always_comb limit = {flt, {FLT_SHIFT{1'b0}}};

    // Two-flop synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s2_q ^ (s1_q ^ s2_q);
        end
    end

    // Hold counter and filtered value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b0;
            cnt_q <= '0;
        end else if (flt == '0) begin
            dout  <= s2_q;
            cnt_q <= '0;
        end else if (s2_q == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == limit - 1'b1) begin
            dout  <= s2_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gim_trigger.sv
// Trigger stage: optional inversion, then level, single-edge or both-edge
// detection. The output is always active high. Both-edge mode ignores the
// invert input.
module gim_trigger
    import gim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  trig_e mode,
    input  logic  invert,
    output logic  irq
);
    logic prev_q;
    logic inv_eff;
    logic cur_v, old_v;

    // Remember last cycle's filtered value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    // Apply polarity and pick the detector.
    always_comb begin
        inv_eff = invert && (mode != TRIG_BOTH);
        cur_v   = din ^ inv_eff;
        old_v   = prev_q ^ inv_eff;
        case (mode)
            TRIG_EDGE: irq = cur_v & ~old_v;
            TRIG_BOTH: irq = din ^ prev_q;
            default:   irq = cur_v;
        endcase
    end
endmodule

// File: rtl/gim_channel.sv
// One interrupt channel: pad select, synchronise/filter, trigger.
// Assumes its configuration comes straight from the register file.
module gim_channel
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  logic [SEL_W-1:0]    sel,
    input  logic [FLT_W-1:0]    flt,
    input  trig_e               mode,
    input  logic                invert,
    output logic                irq
);
    logic picked;
    logic filtered;

    gim_pad_sel #(.NUM_PADS(NUM_PADS)) u_sel (
        .pads   (pads),
        .sel    (sel),
        .picked (picked)
    );

    gim_filter u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (picked),
        .flt   (flt),
        .dout  (filtered)
    );

    gim_trigger u_trg (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (filtered),
        .mode   (mode),
        .invert (invert),
        .irq    (irq)
    );
endmodule

// File: rtl/gim_irq_mux.sv
// Top: register file plus eight channels. Decodes each channel's packed
// fields from the register words. Both-edge overrides edge and polarity.
module gim_irq_mux
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [CH_NUM-1:0]   irq_out
);
    logic [DATA_W-1:0] trig_q, sela_q, selb_q, flt_q;

    gim_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .trig_q (trig_q),
        .sela_q (sela_q),
        .selb_q (selb_q),
        .flt_q  (flt_q)
    );

    generate
        for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
            localparam int SEL_LSB = (c % SEL_PER_REG) * SEL_W;
            logic [SEL_W-1:0] sel_c;
            trig_e            mode_c;

            // Pick this channel's selector from the right word.
            if (c < SEL_PER_REG) begin : g_lo
                assign sel_c = sela_q[SEL_LSB +: SEL_W];
            end else begin : g_hi
                assign sel_c = selb_q[SEL_LSB +: SEL_W];
            end

            // Both-edge bit wins over the single-edge bit.
            always_comb begin
                if (trig_q[BOTH_LSB + c])      mode_c = TRIG_BOTH;
                else if (trig_q[EDGE_LSB + c]) mode_c = TRIG_EDGE;
                else                           mode_c = TRIG_LEVEL;
            end

            gim_channel #(.NUM_PADS(NUM_PADS)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .pads   (pad_in),
                .sel    (sel_c),
                .flt    (flt_q[c*FLT_W +: FLT_W]),
                .mode   (mode_c),
                .invert (trig_q[INV_LSB + c]),
                .irq    (irq_out[c])
            );
        end
    endgenerate
endmodule

// File: rtl/gim_irq_mux_checker.sv
// Property checker bound to gim_irq_mux.
module gim_irq_mux_checker
    import gim_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] trig_q,
    input logic [DATA_W-1:0] sela_q,
    input logic [DATA_W-1:0] flt_q,
    input logic [CH_NUM-1:0] irq_out
);
    // R1: a reset cycle leaves registers clear and outputs low.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (trig_q == '0 && sela_q == '0 && flt_q == '0 && irq_out == '0));

    // R2: the top byte of word 0 reads zero.
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_TRIG) |-> (reg_rdata[31:24] == 8'h00));

    // R2: a write to word 1 lands whole.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_SELA) |=> (sela_q == $past(reg_wdata)));

    generate
        for (genvar c = 0; c < CH_NUM; c++) begin : g_pulse
            // R6 R7: a single-edge pulse lasts one cycle when config is held.
            assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_out[c] && trig_q[EDGE_LSB + c] && !trig_q[BOTH_LSB + c] && !reg_we)
                |=> !irq_out[c]);
        end
    endgenerate
endmodule

bind gim_irq_mux gim_irq_mux_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trig_q    (trig_q),
    .sela_q    (sela_q),
    .flt_q     (flt_q),
    .irq_out   (irq_out)
);

// File: tb/gim_irq_mux_test.sv
module gim_irq_mux_test;
    localparam int PADS = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [PADS-1:0] pad_in = '0;
    logic [7:0]      irq_out;

    int vectors = 0;
    int fails   = 0;

    gim_irq_mux #(.NUM_PADS(PADS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Write all eight selectors at once.
    task automatic set_sels(input logic [7:0] s [8]);
        wr(2'd1, {s[3], s[2], s[1], s[0]});
        wr(2'd2, {s[7], s[6], s[5], s[4]});
    endtask

    function automatic logic [7:0] level_exp(input logic [7:0] s [8],
                                             input logic [PADS-1:0] pat,
                                             input logic inv);
        logic [7:0] e;
        for (int c = 0; c < 8; c++) begin
            e[c] = ((s[c] < PADS) ? pat[s[c]] : 1'b0) ^ inv;
        end
        return e;
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  sels [8];
        logic [PADS-1:0] pats [4];
        pats[0] = 12'hFFF; pats[1] = 12'h000; pats[2] = 12'hA5A; pats[3] = 12'h5A5;

        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1", d, 32'h0);
        end
        chk("R1", {24'h0, irq_out}, 32'h0);

        // R2: register layout and readback
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R2", d, 32'h00FF_FFFF);
        wr(2'd1, 32'h1234_5678); rd(2'd1, d); chk("R2", d, 32'h1234_5678);
        wr(2'd2, 32'h9ABC_DEF0); rd(2'd2, d); chk("R2", d, 32'h9ABC_DEF0);
        wr(2'd3, 32'hC3A5_5A3C); rd(2'd3, d); chk("R2", d, 32'hC3A5_5A3C);
        wr(2'd0, 32'h0); wr(2'd3, 32'h0);

        // R3 R4: level sweep across the whole selector space
        for (int p = 0; p < 256; p += 8) begin
            for (int c = 0; c < 8; c++) sels[c] = 8'((p + c * 3) % 256);
            set_sels(sels);
            for (int q = 0; q < 4; q++) begin
                pad_in = pats[q];
                tick(4);
                chk("R3", {24'h0, irq_out}, {24'h0, level_exp(sels, pats[q], 1'b0)});
            end
        end
        // R3: boundary values just below and at the pad count
        for (int c = 0; c < 8; c++) sels[c] = 8'(PADS - 4 + c);
        set_sels(sels);
        pad_in = 12'hFFF;
        tick(4);
        chk("R3", {24'h0, irq_out}, 32'h0000_000F);

        // R4: exact latency
        for (int c = 0; c < 8; c++) sels[c] = 8'd0;
        set_sels(sels);
        pad_in = '0; tick(4);
        pad_in[0] = 1'b1;
        tick(2); chk("R4", {24'h0, irq_out}, 32'h00);
        tick(1); chk("R4", {24'h0, irq_out}, 32'hFF);

        // R5: inverted level
        wr(2'd0, 32'h00FF_0000);
        for (int c = 0; c < 8; c++) sels[c] = 8'(c + 8);
        set_sels(sels);
        for (int q = 0; q < 4; q++) begin
            pad_in = pats[q];
            tick(4);
            chk("R5", {24'h0, irq_out}, {24'h0, level_exp(sels, pats[q], 1'b1)});
        end

        // R6: rising edge
        for (int c = 0; c < 8; c++) sels[c] = 8'd0;
        set_sels(sels);
        pad_in = '0;
        wr(2'd0, 32'h0000_00FF);
        tick(6);
        pad_in[0] = 1'b1;
        tick(2); chk("R6", {24'h0, irq_out}, 32'h00);
        tick(1); chk("R6", {24'h0, irq_out}, 32'hFF);
        tick(1); chk("R6", {24'h0, irq_out}, 32'h00);
        pad_in[0] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick(1); chk("R6", {24'h0, irq_out}, 32'h00);
        end

        // R7: falling edge
        wr(2'd0, 32'h00FF_00FF);
        tick(6);
        pad_in[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick(1); chk("R7", {24'h0, irq_out}, 32'h00);
        end
        pad_in[0] = 1'b0;
        tick(2); chk("R7", {24'h0, irq_out}, 32'h00);
        tick(1); chk("R7", {24'h0, irq_out}, 32'hFF);
        tick(1); chk("R7", {24'h0, irq_out}, 32'h00);

        // R8: both edges override the edge and invert bits
        wr(2'd0, 32'h00FF_FFFF);
        tick(6);
        chk("R8", {24'h0, irq_out}, 32'h00);
        pad_in[0] = 1'b1;
        tick(2); chk("R8", {24'h0, irq_out}, 32'h00);
        tick(1); chk("R8", {24'h0, irq_out}, 32'hFF);
        tick(1); chk("R8", {24'h0, irq_out}, 32'h00);
        pad_in[0] = 1'b0;
        tick(2); chk("R8", {24'h0, irq_out}, 32'h00);
        tick(1); chk("R8", {24'h0, irq_out}, 32'hFF);
        tick(1); chk("R8", {24'h0, irq_out}, 32'h00);

        // R10: mixed modes; ch5..7 select an out-of-range pad
        wr(2'd0, 32'h000A_100C);
        for (int c = 0; c < 8; c++) sels[c] = (c < 5) ? 8'd0 : 8'd200;
        set_sels(sels);
        tick(6);
        chk("R10", {24'h0, irq_out}, 32'h02);
        pad_in[0] = 1'b1;
        tick(3); chk("R10", {24'h0, irq_out}, 32'h15);
        tick(1); chk("R10", {24'h0, irq_out}, 32'h01);
        pad_in[0] = 1'b0;
        tick(3); chk("R10", {24'h0, irq_out}, 32'h1A);
        tick(1); chk("R10", {24'h0, irq_out}, 32'h02);

        // R9: filter lengths 0..7 on channels 0..7, step response
        wr(2'd0, 32'h0);
        for (int c = 0; c < 8; c++) sels[c] = 8'd0;
        set_sels(sels);
        wr(2'd3, 32'h7654_3210);
        tick(40);
        pad_in[0] = 1'b1;
        for (int k = 1; k <= 34; k++) begin
            logic [7:0] e;
            tick(1);
            for (int c = 0; c < 8; c++) e[c] = (k >= ((c == 0) ? 3 : 2 + 4 * c));
            chk("R9", {24'h0, irq_out}, {24'h0, e});
        end
        // R9: a 3-cycle low glitch passes only the unfiltered channel
        tick(10);
        pad_in[0] = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            tick(1);
            chk("R9", {24'h0, irq_out}, {24'h0, 7'h7F, !(k >= 3 && k <= 5)});
            if (k == 3) pad_in[0] = 1'b1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule